// File: doc/BRIEF.md
# Dual-Port Banked Load Arbiter

This block fronts a data array split into eight banks, each one 64-bit word wide. Two load requests may arrive in the same cycle. Each address is decoded into a bank number and a row index, and the block decides whether both loads can be read in that cycle. Every load returns one whole aligned 64-bit word. The three lowest address bits are ignored, and the whole addressed range counts as resident. A simple write port fills the array before loads are issued.

Two loads only collide when they need different rows of the same bank. When both loads name the same bank and the same row, a single bank read serves both ports. On a collision, port 0 is read at once and port 1 is replayed in the next cycle. A one-cycle stall tells the requester that this replay cycle cannot take new loads.

The controller has two states. `ST_ACCEPT` takes new requests. It moves to `ST_REPLAY` when a collision is seen (transition *collide*) and otherwise stays where it is (transition *flow*). `ST_REPLAY` reads the held port-1 address, drives the stall output and always returns to `ST_ACCEPT` (transition *resume*).

Top module: `bank_load_arbiter`

## Requirements
- R1: While `rst_n` is low, the first clock edge clears `rsp0_valid`, `rsp1_valid` and `stall` to 0.
- R2: The bank is address bits [5:3] and the row index is address bits [14:6]. Address bits [2:0] have no effect on which word is written or read.
- R3: A load accepted on a clock edge presents its response valid and data right after the next edge, one cycle of latency.
- R4: Two valid loads to different banks both return in the next cycle without a stall, whatever their row indices are.
- R5: Two valid loads to the same bank and the same row index do not stall, and both ports return the same word in the next cycle.
- R6: Two valid loads to the same bank with different row indices (for example 0x0000 and 0x0040) are a conflict. Port 0 responds in the next cycle, `stall` is high for exactly that one cycle, and port 1 responds in the cycle after it.
- R7: Requests presented while `stall` is high are ignored and produce no response. The only response in the following cycle is the replayed port 1.
- R8: A cycle with only one request valid, on either port, never raises `stall`.
- R9: When `wr_en` is high, one 64-bit word is written using the same bank and row mapping, and a later load to that word returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req0_valid | input | 1 | Load request on port 0 |
| req0_addr | input | 15 | Byte address of port 0 load |
| req1_valid | input | 1 | Load request on port 1 |
| req1_addr | input | 15 | Byte address of port 1 load |
| wr_en | input | 1 | Write one word |
| wr_addr | input | 15 | Byte address of the written word |
| wr_data | input | 64 | Word to write |
| rsp0_valid | output | 1 | Port 0 data valid |
| rsp0_data | output | 64 | Port 0 load data |
| rsp1_valid | output | 1 | Port 1 data valid |
| rsp1_data | output | 64 | Port 1 load data |
| stall | output | 1 | Replay cycle; new requests are not taken |

## Verification
The assertions assume the requester never uses the write port in a cycle that has a load valid or `stall` high, so no read ever races a write to the same row. The shared-read check also assumes that the word has been written before it is read. The bench fills every word through the write port before any load is issued. In its random phase it only issues a write in cycles where the reference model shows no stall and no load. Load addresses in that phase are drawn from a narrow window, so same-bank collisions, shared rows and requests during a stall all happen often.

// File: rtl/bla_pkg.sv
package bla_pkg;

    typedef enum logic [0:0] {
        ST_ACCEPT = 1'b0,
        ST_REPLAY = 1'b1
    } arb_state_e;

endpackage

// File: rtl/bla_addr_map.sv
module bla_addr_map #(
    parameter int ADDR_W    = 15,
    parameter int BANK_LSB  = 3,
    parameter int BANK_BITS = 3,
    parameter int IDX_BITS  = 9
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [BANK_BITS-1:0] bank,
    output logic [IDX_BITS-1:0]  idx
);

    localparam int IDX_LSB = BANK_LSB + BANK_BITS;

    // Byte-offset bits below the bank field select nothing.
    logic unused_offset;
    assign unused_offset = ^addr[BANK_LSB-1:0];

    assign bank = addr[BANK_LSB +: BANK_BITS];
    assign idx  = addr[IDX_LSB  +: IDX_BITS];

endmodule

// File: rtl/bla_bank.sv
module bla_bank #(
    parameter int IDX_BITS = 9,
    parameter int DATA_W   = 64
) (
    input  logic                clk,
    input  logic                we,
    input  logic [IDX_BITS-1:0] widx,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                re,
    input  logic [IDX_BITS-1:0] ridx,
    output logic [DATA_W-1:0]   rdata
);

    localparam int ROWS = 1 << IDX_BITS;

    logic [DATA_W-1:0] mem [ROWS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[widx] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (re) begin
            rdata <= mem[ridx];
        end
    end

endmodule

// File: rtl/bla_ctrl.sv
module bla_ctrl
    import bla_pkg::*;
#(
    parameter int BANK_BITS = 3,
    parameter int IDX_BITS  = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req0_valid,
    input  logic                 req1_valid,
    input  logic [BANK_BITS-1:0] bank0,
    input  logic [BANK_BITS-1:0] bank1,
    input  logic [IDX_BITS-1:0]  idx0,
    input  logic [IDX_BITS-1:0]  idx1,
    output logic                 serve0,
    output logic                 serve1,
    output logic                 serve_rep,
    output logic                 capture,
    output logic                 stall
);

    arb_state_e state_q;
    arb_state_e state_d;
    logic       collide;

    assign collide = req0_valid && req1_valid && (bank0 == bank1) && (idx0 != idx1);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ACCEPT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        serve0    = 1'b0;
        serve1    = 1'b0;
        serve_rep = 1'b0;
        capture   = 1'b0;
        stall     = 1'b0;
        unique case (state_q)
            ST_ACCEPT: begin
                serve0 = req0_valid;
                serve1 = req1_valid && !collide;
                if (collide) begin
                    capture = 1'b1;
                    state_d = ST_REPLAY;   // collide
                end else begin
                    state_d = ST_ACCEPT;   // flow
                end
            end
            ST_REPLAY: begin
                serve_rep = 1'b1;
                stall     = 1'b1;
                state_d   = ST_ACCEPT;     // resume
            end
            default: begin
                state_d = ST_ACCEPT;
            end
        endcase
    end

endmodule

// File: rtl/bank_load_arbiter.sv
module bank_load_arbiter
    import bla_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 64,
    parameter int BANK_LSB  = 3,
    parameter int BANK_BITS = 3,
    parameter int IDX_BITS  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req0_valid,
    input  logic [ADDR_W-1:0] req0_addr,
    input  logic              req1_valid,
    input  logic [ADDR_W-1:0] req1_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rsp0_valid,
    output logic [DATA_W-1:0] rsp0_data,
    output logic              rsp1_valid,
    output logic [DATA_W-1:0] rsp1_data,
    output logic              stall
);

    localparam int NUM_BANKS = 1 << BANK_BITS;

    logic [BANK_BITS-1:0] bank0, bank1, wbank;
    logic [IDX_BITS-1:0]  idx0, idx1, widx;

    bla_addr_map #(
        .ADDR_W(ADDR_W), .BANK_LSB(BANK_LSB), .BANK_BITS(BANK_BITS), .IDX_BITS(IDX_BITS)
    ) u_map0 (
        .addr(req0_addr), .bank(bank0), .idx(idx0)
    );

    bla_addr_map #(
        .ADDR_W(ADDR_W), .BANK_LSB(BANK_LSB), .BANK_BITS(BANK_BITS), .IDX_BITS(IDX_BITS)
    ) u_map1 (
        .addr(req1_addr), .bank(bank1), .idx(idx1)
    );

    bla_addr_map #(
        .ADDR_W(ADDR_W), .BANK_LSB(BANK_LSB), .BANK_BITS(BANK_BITS), .IDX_BITS(IDX_BITS)
    ) u_mapw (
        .addr(wr_addr), .bank(wbank), .idx(widx)
    );

    logic serve0, serve1, serve_rep, capture;

    bla_ctrl #(
        .BANK_BITS(BANK_BITS), .IDX_BITS(IDX_BITS)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req0_valid(req0_valid),
        .req1_valid(req1_valid),
        .bank0     (bank0),
        .bank1     (bank1),
        .idx0      (idx0),
        .idx1      (idx1),
        .serve0    (serve0),
        .serve1    (serve1),
        .serve_rep (serve_rep),
        .capture   (capture),
        .stall     (stall)
    );

    // Port-1 location held for the replay cycle
    logic [BANK_BITS-1:0] rep_bank_q;
    logic [IDX_BITS-1:0]  rep_idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rep_bank_q <= '0;
            rep_idx_q  <= '0;
        end else if (capture) begin
            rep_bank_q <= bank1;
            rep_idx_q  <= idx1;
        end
    end

    // One read port per bank
    logic [DATA_W-1:0] bank_rdata [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic                hit0, hit1, hitr;
        logic                re;
        logic [IDX_BITS-1:0] ridx;

        assign hit0 = serve0    && (bank0      == BANK_BITS'(b));
        assign hit1 = serve1    && (bank1      == BANK_BITS'(b));
        assign hitr = serve_rep && (rep_bank_q == BANK_BITS'(b));
        assign re   = hit0 || hit1 || hitr;

        always_comb begin
            if (hit0) begin
                ridx = idx0;
            end else if (hit1) begin
                ridx = idx1;
            end else begin
                ridx = rep_idx_q;
            end
        end

        bla_bank #(
            .IDX_BITS(IDX_BITS), .DATA_W(DATA_W)
        ) u_bank (
            .clk  (clk),
            .we   (wr_en && (wbank == BANK_BITS'(b))),
            .widx (widx),
            .wdata(wr_data),
            .re   (re),
            .ridx (ridx),
            .rdata(bank_rdata[b])
        );
    end

    // Response steering, aligned with the bank read latency
    logic                 rsp0_valid_q, rsp1_valid_q;
    logic [BANK_BITS-1:0] rsp0_bank_q, rsp1_bank_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp0_valid_q <= 1'b0;
            rsp1_valid_q <= 1'b0;
            rsp0_bank_q  <= '0;
            rsp1_bank_q  <= '0;
        end else begin
            rsp0_valid_q <= serve0;
            rsp1_valid_q <= serve1 || serve_rep;
            rsp0_bank_q  <= bank0;
            rsp1_bank_q  <= serve_rep ? rep_bank_q : bank1;
        end
    end

    assign rsp0_valid = rsp0_valid_q;
    assign rsp1_valid = rsp1_valid_q;
    assign rsp0_data  = bank_rdata[rsp0_bank_q];
    assign rsp1_data  = bank_rdata[rsp1_bank_q];

endmodule

// File: rtl/bla_checker.sv
module bla_checker #(
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 64,
    parameter int BANK_LSB  = 3,
    parameter int BANK_BITS = 3,
    parameter int IDX_BITS  = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req0_valid,
    input logic [ADDR_W-1:0] req0_addr,
    input logic              req1_valid,
    input logic [ADDR_W-1:0] req1_addr,
    input logic              wr_en,
    input logic              rsp0_valid,
    input logic [DATA_W-1:0] rsp0_data,
    input logic              rsp1_valid,
    input logic [DATA_W-1:0] rsp1_data,
    input logic              stall
);

    localparam int IDX_LSB = BANK_LSB + BANK_BITS;

    logic same_bank, same_idx, both;
    assign same_bank = req0_addr[BANK_LSB +: BANK_BITS] == req1_addr[BANK_LSB +: BANK_BITS];
    assign same_idx  = req0_addr[IDX_LSB +: IDX_BITS]   == req1_addr[IDX_LSB +: IDX_BITS];
    assign both      = req0_valid && req1_valid && !stall;

    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (!rsp0_valid && !rsp1_valid && !stall));

    p_load_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req0_valid && !stall) |=> rsp0_valid);

    p_pair_together_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (both && !same_bank) |=> (rsp0_valid && rsp1_valid && !stall));

    p_shared_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (both && same_bank && same_idx) |=> (rsp1_valid && !stall && rsp0_data == rsp1_data));

    p_conflict_split_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (both && same_bank && !same_idx) |=> (stall && rsp0_valid && !rsp1_valid));

    p_stall_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    p_replay_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (rsp1_valid && !rsp0_valid));

    p_lone_request_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && (req0_valid != req1_valid)) |=> !stall);

    // Input assumption for R9: writes only on idle cycles
    p_write_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (!req0_valid && !req1_valid && !stall));

endmodule

bind bank_load_arbiter bla_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_LSB(BANK_LSB),
    .BANK_BITS(BANK_BITS), .IDX_BITS(IDX_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req0_valid(req0_valid),
    .req0_addr (req0_addr),
    .req1_valid(req1_valid),
    .req1_addr (req1_addr),
    .wr_en     (wr_en),
    .rsp0_valid(rsp0_valid),
    .rsp0_data (rsp0_data),
    .rsp1_valid(rsp1_valid),
    .rsp1_data (rsp1_data),
    .stall     (stall)
);

// File: tb/bank_load_arbiter_tb.sv
module bank_load_arbiter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 15;
    localparam int DW = 64;
    localparam int WORDS = 4096;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req0_valid = 1'b0, req1_valid = 1'b0, wr_en = 1'b0;
    logic [AW-1:0] req0_addr = '0, req1_addr = '0, wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          rsp0_valid, rsp1_valid, stall;
    logic [DW-1:0] rsp0_data, rsp1_data;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_load_arbiter u_dut (
        .clk(clk), .rst_n(rst_n),
        .req0_valid(req0_valid), .req0_addr(req0_addr),
        .req1_valid(req1_valid), .req1_addr(req1_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rsp0_valid(rsp0_valid), .rsp0_data(rsp0_data),
        .rsp1_valid(rsp1_valid), .rsp1_data(rsp1_data),
        .stall(stall)
    );

    // Reference model state
    logic [DW-1:0] model [WORDS];
    bit            m_stall = 1'b0;
    logic [DW-1:0] m_pend  = '0;

    function automatic logic [DW-1:0] pattern(input int w);
        return {32'(w) * 32'h9E37_79B1, ~32'(w) ^ 32'h5A5A_5A5A};
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One clock: drive inputs, predict, then compare after the edge
    task automatic step(input logic v0, input logic [AW-1:0] a0,
                        input logic v1, input logic [AW-1:0] a1,
                        input logic we, input logic [AW-1:0] wa,
                        input logic [DW-1:0] wd, input string tag);
        logic          ev0, ev1, es, clash;
        logic [DW-1:0] ed0, ed1;
        req0_valid = v0; req0_addr = a0;
        req1_valid = v1; req1_addr = a1;
        wr_en = we; wr_addr = wa; wr_data = wd;
        ed0 = '0; ed1 = '0;
        if (m_stall) begin
            ev0 = 1'b0; ev1 = 1'b1; ed1 = m_pend; es = 1'b0;
        end else begin
            clash = v0 && v1 && (a0[5:3] == a1[5:3]) && (a0[14:6] != a1[14:6]);
            ev0 = v0; ed0 = model[a0[14:3]];
            ev1 = v1 && !clash; ed1 = model[a1[14:3]];
            es = clash;
            if (clash) m_pend = model[a1[14:3]];
        end
        if (we) model[wa[14:3]] = wd;
        m_stall = es;
        @(posedge clk); #1;
        check(tag, "stall", DW'(stall), DW'(es));
        check(tag, "rsp0_valid", DW'(rsp0_valid), DW'(ev0));
        check(tag, "rsp1_valid", DW'(rsp1_valid), DW'(ev1));
        if (ev0) check(tag, "rsp0_data", rsp0_data, ed0);
        if (ev1) check(tag, "rsp1_data", rsp1_data, ed1);
    endtask

    task automatic idle(input string tag);
        step(1'b0, '0, 1'b0, '0, 1'b0, '0, '0, tag);
    endtask

    initial begin
        // R1: reset state
        repeat (2) @(posedge clk);
        #1;
        check("R1", "stall", DW'(stall), '0);
        check("R1", "rsp0_valid", DW'(rsp0_valid), '0);
        check("R1", "rsp1_valid", DW'(rsp1_valid), '0);
        rst_n = 1'b1;

        // R9 / R2: fill every word, with junk in bits [2:0]
        for (int w = 0; w < WORDS; w++) begin
            step(1'b0, '0, 1'b0, '0, 1'b1, AW'((w << 3) | (w % 8)), pattern(w), "R9");
        end
        idle("R9");

        // R8 + R2: single load on each port, offset bits ignored
        step(1'b1, 15'h0008 | 15'h5, 1'b0, '0, 1'b0, '0, '0, "R8");
        step(1'b0, '0, 1'b1, 15'h1237, 1'b0, '0, '0, "R8");
        idle("R3");

        // R4: different banks, different rows
        step(1'b1, 15'h0000, 1'b1, 15'h0048, 1'b0, '0, '0, "R4");
        step(1'b1, 15'h7FF8, 1'b1, 15'h0010, 1'b0, '0, '0, "R4");

        // R5: same bank, same row, different offsets
        step(1'b1, 15'h0010, 1'b1, 15'h0017, 1'b0, '0, '0, "R5");

        // R6: 0x0000 vs 0x0040, then R7: requests during stall are dropped
        step(1'b1, 15'h0000, 1'b1, 15'h0040, 1'b0, '0, '0, "R6");
        step(1'b1, 15'h0100, 1'b1, 15'h0208, 1'b0, '0, '0, "R7");
        idle("R7");

        // R6: back-to-back conflicts
        step(1'b1, 15'h0238, 1'b1, 15'h7FF8, 1'b0, '0, '0, "R6");
        step(1'b0, '0, 1'b0, '0, 1'b0, '0, '0, "R6");
        step(1'b1, 15'h1020, 1'b1, 15'h2060, 1'b0, '0, '0, "R6");
        idle("R6");

        // R9: overwrite then read back through both ports
        step(1'b0, '0, 1'b0, '0, 1'b1, 15'h0040, 64'hDEAD_BEEF_0123_4567, "R9");
        step(1'b1, 15'h0042, 1'b1, 15'h0000, 1'b0, '0, '0, "R9");
        idle("R9");

        // Random mix in a narrow window
        for (int i = 0; i < 3000; i++) begin
            logic v0, v1, we;
            logic [AW-1:0] a0, a1;
            v0 = ($urandom % 4) != 0;
            v1 = ($urandom % 4) != 0;
            a0 = AW'($urandom) & 15'h03FF;
            a1 = AW'($urandom) & 15'h03FF;
            we = !m_stall && !v0 && !v1 && (($urandom % 2) == 0);
            if (m_stall) we = 1'b0;
            step(v0, a0, v1, a1, we, AW'($urandom) & 15'h03FF,
                 {32'($urandom), 32'($urandom)}, "R3");
        end
        idle("R3");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule